// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a chain of boundary scan cells, one per functional pin, placed between the chip's pins and its core logic. Every cell holds a capture/shift stage, clocked by the test clock, and a separate update stage. Its serial input comes from the cell before it, so all the cells form a single shift register. That shift register can be linked with the chains of other chips on a board. An external test access port controller drives the capture, shift, update and mode controls.

When the mode input is low, each cell passes its parallel input straight through to its parallel output. When the mode input is high, each cell drives its parallel output from its update stage, whatever its parallel input is doing. This separates the core from the pins. It lets any chosen combination of values be applied to output pins and core inputs. Values on input pins or core outputs are sampled through the parallel inputs and then shifted out serially for inspection.

Top module: `bscan_chain`

## Requirements
- R1: A synchronous active-high reset clears every capture/shift stage and every update stage to 0. After reset the serial output reads 0, and with mode high every parallel output reads 0.
- R2: With mode low, every parallel output equals its parallel input in the same cycle, with no clock delay.
- R3: With mode high, every parallel output equals its cell's update stage and does not depend on the parallel input.
- R4: A clock edge with capture=1 and shift=0 loads every cell's capture/shift stage from its own parallel input.
- R5: A clock edge with shift=1 moves cell k-1's stage into cell k and loads cell 0 from the chain's serial input. Shift takes priority over capture when both are high.
- R6: The serial output is the stage of the last cell, index N-1. After exactly N shifts, the bits shifted in appear at the serial output, first bit first, during the next N shifts. Shifting in bit value P[N-1-i] at shift step i leaves cell k holding P[k].
- R7: An update stage loads only on an edge with update=1. It then takes the value its capture/shift stage held before that edge. The parallel outputs in mode high stay stable while data is shifted or captured.
- R8: On an edge with capture=0 and shift=0, every capture/shift stage keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 = cells drive the parallel outputs from the update stages; 0 = pass-through |
| capture | input | 1 | Load the parallel inputs into the capture/shift stages |
| shift | input | 1 | Shift the chain by one cell |
| update | input | 1 | Copy the capture/shift stages into the update stages |
| sdi | input | 1 | Serial input to cell 0 |
| par_in | input | N_CELLS | Parallel inputs, bit k belongs to cell k |
| par_out | output | N_CELLS | Parallel outputs, bit k belongs to cell k |
| sdo | output | 1 | Serial output from cell N_CELLS-1 |

## Verification
A corrupted capture/shift stage becomes visible at sdo only when it reaches the last cell, so it can stay hidden for up to N shifts. The bench therefore shifts out a full word after every load or capture. A wrong update stage shows on par_out in mode high in the cycle right after the update edge. An update stage that changes at the wrong moment shows as a change on par_out during a shift that should have left it alone. The pass-through path is combinational, so a fault there shows in the same cycle that par_in changes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } scan_op_e;

    typedef struct packed {
        logic stage;
        logic held;
    } cell_state_t;

    function automatic scan_op_e pick_op(input logic cap_i, input logic shf_i);
        if (shf_i)      return OP_SHIFT;
        else if (cap_i) return OP_CAPTURE;
        else            return OP_HOLD;
    endfunction

endpackage

// File: rtl/bscan_op_decode.sv
module bscan_op_decode
    import bscan_pkg::*;
(
    input  logic     capture,
    input  logic     shift,
    output scan_op_e op
);
    always_comb begin
        op = pick_op(capture, shift);
    end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  scan_op_e op,
    input  logic     upd_en,
    input  logic     test_mode,
    input  logic     pin_val,
    input  logic     ser_in,
    output logic     core_val,
    output logic     ser_out,
    output logic     held_out
);
    cell_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (op)
                OP_SHIFT:   st.stage <= ser_in;
                OP_CAPTURE: st.stage <= pin_val;
                default:    st.stage <= st.stage;
            endcase
            if (upd_en) st.held <= st.stage;
        end
    end

    always_comb begin
        ser_out  = st.stage;
        held_out = st.held;
        core_val = test_mode ? st.held : pin_val;
    end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               test_mode,
    input  logic               capture,
    input  logic               shift,
    input  logic               update,
    input  logic               sdi,
    input  logic [N_CELLS-1:0] par_in,
    output logic [N_CELLS-1:0] par_out,
    output logic               sdo
);
    localparam int LAST = N_CELLS - 1;

    scan_op_e           op;
    logic [N_CELLS:0]   link;
    logic [N_CELLS-1:0] cap_q;
    logic [N_CELLS-1:0] upd_q;

    bscan_op_decode u_dec (
        .capture (capture),
        .shift   (shift),
        .op      (op)
    );

    assign link[0] = sdi;

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        bscan_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .op        (op),
            .upd_en    (update),
            .test_mode (test_mode),
            .pin_val   (par_in[k]),
            .ser_in    (link[k]),
            .core_val  (par_out[k]),
            .ser_out   (link[k+1]),
            .held_out  (upd_q[k])
        );
        assign cap_q[k] = link[k+1];
    end

    assign sdo = cap_q[LAST];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N_CELLS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               test_mode,
    input logic               capture,
    input logic               shift,
    input logic               update,
    input logic               sdi,
    input logic [N_CELLS-1:0] par_in,
    input logic [N_CELLS-1:0] par_out,
    input logic               sdo,
    input logic [N_CELLS-1:0] cap_q,
    input logic [N_CELLS-1:0] upd_q
);
    // R1: reset clears both stages
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cap_q == '0 && upd_q == '0));

    // R2: pass-through with mode low
    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> par_out == par_in);

    // R3: mode-high outputs ignore par_in changes unless an update occurred
    assert_isolate_R3: assert property (@(posedge clk) disable iff (rst)
        (test_mode && $past(test_mode) && !$past(update) && !$past(rst)) |-> $stable(par_out));

    // R4: capture loads parallel inputs
    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (capture && !shift) |=> cap_q == $past(par_in));

    // R5: shift feeds cell 0 from sdi and moves the rest along
    assert_shift_head_R5: assert property (@(posedge clk) disable iff (rst)
        shift |=> cap_q[0] == $past(sdi));
    assert_shift_tail_R5: assert property (@(posedge clk) disable iff (rst)
        shift |=> cap_q[N_CELLS-1:1] == $past(cap_q[N_CELLS-2:0]));

    // R6: serial output is the last stage
    assert_sdo_last_R6: assert property (@(posedge clk) disable iff (rst)
        sdo == cap_q[N_CELLS-1]);

    // R7: update copies the pre-edge stages; otherwise update stages hold
    assert_update_R7: assert property (@(posedge clk) disable iff (rst)
        update |=> upd_q == $past(cap_q));
    assert_upd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !update |=> $stable(upd_q));

    // R8: idle edges keep the capture/shift stages
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!capture && !shift) |=> $stable(cap_q));
endmodule

bind bscan_chain bscan_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .capture   (capture),
    .shift     (shift),
    .update    (update),
    .sdi       (sdi),
    .par_in    (par_in),
    .par_out   (par_out),
    .sdo       (sdo),
    .cap_q     (cap_q),
    .upd_q     (upd_q)
);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
    localparam int N = 8;
    localparam int NV = 6;
    // each entry: {pattern to load, value presented on par_in for capture}
    localparam logic [2*N-1:0] VEC [NV] = '{
        {8'hA5, 8'h3C}, {8'hFF, 8'h00}, {8'h00, 8'hFF},
        {8'h81, 8'h7E}, {8'h01, 8'h80}, {8'h5A, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst, test_mode, capture, shift, update, sdi;
    logic [N-1:0] par_in, par_out;
    logic sdo;
    int compared = 0, mismatched = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bscan_chain #(.N_CELLS(N)) i_bscan_chain (
        .clk(clk), .rst(rst), .test_mode(test_mode), .capture(capture),
        .shift(shift), .update(update), .sdi(sdi),
        .par_in(par_in), .par_out(par_out), .sdo(sdo)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [N-1:0] din, output logic [N-1:0] dout);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            shift = 1'b1;
            sdi = din[N-1-i];
            #1 dout[N-1-i] = sdo;
        end
        @(negedge clk);
        shift = 1'b0;
        sdi = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
    endtask

    task automatic pulse_capture();
        @(negedge clk); capture = 1'b1;
        @(negedge clk); capture = 1'b0;
    endtask

    initial begin
        logic [N-1:0] got, prev, ld, cp;
        rst = 1; test_mode = 0; capture = 0; shift = 0; update = 0; sdi = 0;
        par_in = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        test_mode = 1; par_in = 8'hFF;
        #1;
        chk("R1 par_out after reset", par_out, '0);
        chk("R1 sdo after reset", {7'b0, sdo}, '0);

        // R2 pass-through
        test_mode = 0;
        for (int v = 0; v < 4; v++) begin
            par_in = 8'h33 << v;
            #1 chk("R2 pass-through", par_out, 8'h33 << v);
        end

        // table walk: R3, R4, R6, R7
        test_mode = 1;
        prev = '0;
        for (int e = 0; e < NV; e++) begin
            ld = VEC[e][2*N-1:N];
            cp = VEC[e][N-1:0];
            par_in = cp;
            shift_word(ld, got);
            #1 chk("R7 par_out stable while shifting", par_out, prev);
            pulse_update();
            #1 chk("R3 par_out from update stage", par_out, ld);
            par_in = ~cp;
            #1 chk("R3 par_out ignores par_in", par_out, ld);
            par_in = cp;
            shift_word('0, got);
            chk("R6 N shifts reproduce pattern", got, ld);
            pulse_capture();
            shift_word('0, got);
            chk("R4 captured parallel inputs", got, cp);
            #1 chk("R7 par_out stable across capture", par_out, ld);
            prev = ld;
        end

        // R5 shift wins over capture
        shift_word(8'h96, got);
        par_in = 8'h00;
        @(negedge clk); shift = 1; capture = 1; sdi = 1;
        @(negedge clk); shift = 0; capture = 0; sdi = 0;
        shift_word('0, got);
        chk("R5 shift has priority over capture", got, 8'h2D);

        // R8 hold on idle edges while par_in moves
        shift_word(8'hC9, got);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); par_in = par_in + 8'h17;
        end
        shift_word('0, got);
        chk("R8 stages hold when idle", got, 8'hC9);

        // R7 update in same edge as a shift takes pre-edge stages
        shift_word(8'h6B, got);
        @(negedge clk); shift = 1; update = 1; sdi = 0;
        @(negedge clk); shift = 0; update = 0;
        #1 chk("R7 update uses pre-edge value", par_out, 8'h6B);
        shift_word('0, got);
        chk("R5 one shift then read out", got, 8'hD6);

        // R1 reset mid-operation
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        #1 chk("R1 par_out after second reset", par_out, '0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule